// File: doc/BRIEF.md
# Load/Store Data Alignment Path

This block sits between an integer core and a 32-bit data memory that is addressed by word and has one write enable per byte. For each access request it adds the base register value to a signed 12-bit offset to form the byte address. A 3-bit access code gives the size and signedness. For stores, the block places the low bits of the store operand into the byte lanes that the address selects, and it drives the matching byte enables.

For loads, the memory returns the addressed word one cycle after the request. The block keeps the lane offset and the access code from the request cycle. In the following cycle it selects the byte, halfword or word from the returned data and extends it to the full width, with zeros or with copies of the sign bit. Memory is little-endian.

An access whose address does not match its size is never sent to memory. The block reports it on a flag so that the core can decide what to do. An unsupported access code also produces no memory traffic.

Top module: `lsu_datapath`

## Requirements
- R1: `mem_addr_o` equals `base_i` plus `offset_i` sign-extended from 12 bits, modulo 2^32.
- R2: `misaligned_o` is high only for a valid request with a supported code where either a halfword has address bit 0 set or a word has address bits [1:0] not equal to 00. A byte access never raises it.
- R3: When `misaligned_o` is high, `mem_req_o` and `mem_we_o` are low and `mem_be_o` is 0000, so memory is left unchanged.
- R4: Store byte enables are 1111 for a word, 0011 or 1100 for a halfword when address bit 1 is 0 or 1, and 0001 shifted left by address bits [1:0] for a byte. Loads drive 0000.
- R5: On every enabled lane, `mem_wdata_o` carries byte 0 of `store_data_i` for a byte store, bytes 0 and 1 (low byte in the lower lane) for a halfword, and all four bytes in place for a word.
- R6: Access codes are 000 signed byte, 001 signed half, 010 word, 100 unsigned byte and 101 unsigned half. Stores accept only 000, 001 and 010. Any other code gives no memory request and no load response.
- R7: `load_valid_o` is high in exactly the cycle after an accepted load request, and it is low in every other cycle. In that cycle `load_data_o` is formed from `mem_rdata_i`.
- R8: A word load returns `mem_rdata_i` unchanged.
- R9: A signed byte or signed halfword load returns the lane selected by the address, sign-extended to 32 bits.
- R10: An unsigned byte or unsigned halfword load returns the selected lane, zero-extended to 32 bits.
- R11: While `rst_ni` is low and after reset, `load_valid_o` is low until a load is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_store_i | input | 1 | 1 for a store, 0 for a load |
| funct3_i | input | 3 | Access size and signedness code |
| base_i | input | 32 | Base register value |
| offset_i | input | 12 | Signed immediate offset |
| store_data_i | input | 32 | Store operand (second source register) |
| mem_addr_o | output | 32 | Effective byte address |
| mem_req_o | output | 1 | Memory access issued |
| mem_we_o | output | 1 | Memory write |
| mem_be_o | output | 4 | Byte write enables |
| mem_wdata_o | output | 32 | Lane-aligned write data |
| mem_rdata_i | input | 32 | Read word, one cycle after the request |
| misaligned_o | output | 1 | Access suppressed for misalignment |
| load_valid_o | output | 1 | Load result valid |
| load_data_o | output | 32 | Aligned and extended load result |

## Verification
The bench sweeps every access code against every byte offset, for both loads and stores. It reads back test words whose lanes sit on both sides of the sign boundary. A design that picks the wrong lane, or that extends from bit 15 when it should use bit 7, returns values that differ in the upper bits. Halfword loads at offset 2 catch a design that ignores address bit 1. A round trip of stores followed by word loads catches enables that fire on the wrong lane, and it catches a misaligned word store that still reaches memory. The offset sweep includes negative offsets and wraparound, which catch an offset that is zero-extended.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  typedef struct packed {
    size_e size;
    logic  zext;
    logic  ld_ok;
    logic  st_ok;
  } access_t;

  function automatic access_t decode_f3(input logic [2:0] f3);
    access_t a;
    a = '{size: SZ_BYTE, zext: 1'b0, ld_ok: 1'b0, st_ok: 1'b0};
    unique case (f3)
      3'b000: a = '{size: SZ_BYTE, zext: 1'b0, ld_ok: 1'b1, st_ok: 1'b1};
      3'b001: a = '{size: SZ_HALF, zext: 1'b0, ld_ok: 1'b1, st_ok: 1'b1};
      3'b010: a = '{size: SZ_WORD, zext: 1'b0, ld_ok: 1'b1, st_ok: 1'b1};
      3'b100: a = '{size: SZ_BYTE, zext: 1'b1, ld_ok: 1'b1, st_ok: 1'b0};
      3'b101: a = '{size: SZ_HALF, zext: 1'b1, ld_ok: 1'b1, st_ok: 1'b0};
      default: ;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  parameter int OFF_W  = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  offset_i,
  input  size_e             size_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              misal_o
);

  logic [ADDR_W-1:0] off_ext;

  assign off_ext = {{(ADDR_W-IMM_W){offset_i[IMM_W-1]}}, offset_i};
  assign addr_o  = base_i + off_ext;

  always_comb begin
    unique case (size_i)
      SZ_HALF: misal_o = addr_o[0];
      SZ_WORD: misal_o = |addr_o[OFF_W-1:0];
      default: misal_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/lsu_store_align.sv
module lsu_store_align
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic              en_i,
  input  size_e             size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [NB-1:0]     be_o,
  output logic [DATA_W-1:0] wdata_o
);

  // replication puts the operand on every lane; enables pick the live ones
  for (genvar l = 0; l < NB; l++) begin : g_lane
    always_comb begin
      unique case (size_i)
        SZ_BYTE: wdata_o[8*l +: 8] = data_i[7:0];
        SZ_HALF: wdata_o[8*l +: 8] = data_i[8*(l%2) +: 8];
        default: wdata_o[8*l +: 8] = data_i[8*l +: 8];
      endcase
    end
  end

  always_comb begin
    be_o = '0;
    if (en_i) begin
      unique case (size_i)
        SZ_BYTE: be_o = NB'(1) << off_i;
        SZ_HALF: be_o = NB'(3) << {off_i[OFF_W-1:1], 1'b0};
        SZ_WORD: be_o = '1;
        default: be_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/lsu_load_align.sv
module lsu_load_align
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  size_e             size_i,
  input  logic              zext_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] shifted;
  logic              sb_byte, sb_half;

  assign shifted = rdata_i >> {off_i, 3'b000};
  assign sb_byte = ~zext_i & shifted[7];
  assign sb_half = ~zext_i & shifted[15];

  always_comb begin
    unique case (size_i)
      SZ_BYTE: data_o = {{(DATA_W-8){sb_byte}}, shifted[7:0]};
      SZ_HALF: data_o = {{(DATA_W-16){sb_half}}, shifted[15:0]};
      default: data_o = rdata_i;
    endcase
  end

endmodule

// File: rtl/lsu_datapath.sv
module lsu_datapath
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [2:0]        funct3_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] store_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [NB-1:0]     mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              misaligned_o,
  output logic              load_valid_o,
  output logic [DATA_W-1:0] load_data_o
);

  access_t          acc;
  logic             legal;
  logic             misal_raw;
  logic             ld_accept;

  logic             ld_pend_q;
  logic [OFF_W-1:0] ld_off_q;
  size_e            ld_size_q;
  logic             ld_zext_q;

  assign acc   = decode_f3(funct3_i);
  assign legal = req_store_i ? acc.st_ok : acc.ld_ok;

  lsu_addr_gen #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W),
    .OFF_W  (OFF_W)
  ) i_addr_gen (
    .base_i   (base_i),
    .offset_i (offset_i),
    .size_i   (acc.size),
    .addr_o   (mem_addr_o),
    .misal_o  (misal_raw)
  );

  assign misaligned_o = req_valid_i & legal & misal_raw;
  assign mem_req_o    = req_valid_i & legal & ~misal_raw;
  assign mem_we_o     = mem_req_o & req_store_i;
  assign ld_accept    = mem_req_o & ~req_store_i;

  lsu_store_align #(
    .DATA_W (DATA_W)
  ) i_store_align (
    .en_i    (mem_we_o),
    .size_i  (acc.size),
    .off_i   (mem_addr_o[OFF_W-1:0]),
    .data_i  (store_data_i),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o)
  );

  // memory answers one cycle later: hold lane and format until then
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_pend_q <= 1'b0;
      ld_off_q  <= '0;
      ld_size_q <= SZ_WORD;
      ld_zext_q <= 1'b0;
    end else begin
      ld_pend_q <= ld_accept;
      if (ld_accept) begin
        ld_off_q  <= mem_addr_o[OFF_W-1:0];
        ld_size_q <= acc.size;
        ld_zext_q <= acc.zext;
      end
    end
  end

  lsu_load_align #(
    .DATA_W (DATA_W)
  ) i_load_align (
    .size_i  (ld_size_q),
    .zext_i  (ld_zext_q),
    .off_i   (ld_off_q),
    .rdata_i (mem_rdata_i),
    .data_o  (load_data_o)
  );

  assign load_valid_o = ld_pend_q;

endmodule

// File: rtl/lsu_datapath_chk.sv
module lsu_datapath_chk #(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_store_i,
  input logic [2:0]        funct3_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [NB-1:0]     mem_be_o,
  input logic              misaligned_o,
  input logic              load_valid_o,
  input logic [DATA_W-1:0] load_data_o
);

  AST_MISALIGN_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    misaligned_o |-> (!mem_req_o && !mem_we_o && mem_be_o == '0)); // R3

  AST_WRITE_IS_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_req_o && req_store_i)); // R6

  AST_BYTE_ONE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && funct3_i == 3'b000) |-> $countones(mem_be_o) == 1); // R4

  AST_HALF_TWO_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && funct3_i == 3'b001) |-> $countones(mem_be_o) == 2); // R4

  AST_WORD_ALL_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && funct3_i == 3'b010) |-> &mem_be_o); // R4

  AST_LOAD_NO_ENABLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !req_store_i) |-> mem_be_o == '0); // R4

  AST_LOAD_ANSWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !req_store_i) |=> load_valid_o); // R7

  AST_NO_STRAY_ANSWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && !req_store_i) |=> !load_valid_o); // R7

  AST_UBYTE_ZERO_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_valid_o && $past(funct3_i) == 3'b100) |-> load_data_o[DATA_W-1:8] == '0); // R10

endmodule

bind lsu_datapath lsu_datapath_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_lsu_datapath.sv
module test_lsu_datapath;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_valid_i, req_store_i;
  logic [2:0]  funct3_i;
  logic [31:0] base_i, store_data_i, mem_rdata_i;
  logic [11:0] offset_i;
  logic [31:0] mem_addr_o, mem_wdata_o, load_data_o;
  logic        mem_req_o, mem_we_o, misaligned_o, load_valid_o;
  logic [3:0]  mem_be_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] mem [16];

  always #4 clk_i = ~clk_i;

  lsu_datapath i_lsu_datapath (.*);

  always @(posedge clk_i) begin
    if (mem_we_o)
      for (int b = 0; b < 4; b++)
        if (mem_be_o[b]) mem[mem_addr_o[5:2]][8*b +: 8] <= mem_wdata_o[8*b +: 8];
    if (mem_req_o && !mem_we_o) mem_rdata_i <= mem[mem_addr_o[5:2]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input bit st, input logic [2:0] f, input logic [31:0] b,
                       input logic [11:0] o, input logic [31:0] sd);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_store_i = st; funct3_i = f;
    base_i = b; offset_i = o; store_data_i = sd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_valid_i = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] exp_load(input int f, input int a, input logic [31:0] w);
    logic [31:0] s;
    s = w >> (8 * a);
    case (f)
      0: return {{24{s[7]}}, s[7:0]};
      1: return {{16{s[15]}}, s[15:0]};
      4: return {24'h0, s[7:0]};
      5: return {16'h0, s[15:0]};
      default: return w;
    endcase
  endfunction

  task automatic load_word(input logic [31:0] a, input logic [31:0] exp, input string req);
    drive(1'b0, 3'b010, a, 12'h0, 32'h0);
    idle();
    chk(req, load_data_o, exp);
  endtask

  initial begin
    rst_ni = 1'b0; req_valid_i = 1'b0; req_store_i = 1'b0; funct3_i = '0;
    base_i = '0; offset_i = '0; store_data_i = '0;
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R11 reset", {31'h0, load_valid_o}, 32'h0);
    chk("R11 reset req", {31'h0, mem_req_o}, 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk("R11 after reset", {31'h0, load_valid_o}, 32'h0);

    // R1: address sum with sign-extended offset (illegal code keeps memory quiet)
    drive(1'b1, 3'b011, 32'h0000_0100, 12'h004, 0); chk("R1", mem_addr_o, 32'h0000_0104);
    drive(1'b1, 3'b011, 32'h0000_0100, 12'hFFC, 0); chk("R1", mem_addr_o, 32'h0000_00FC);
    drive(1'b1, 3'b011, 32'hFFFF_FFFF, 12'h001, 0); chk("R1", mem_addr_o, 32'h0000_0000);
    drive(1'b1, 3'b011, 32'h0000_0010, 12'h800, 0); chk("R1", mem_addr_o, 32'hFFFF_F810);
    drive(1'b1, 3'b011, 32'h0000_1234, 12'h7FF, 0); chk("R1", mem_addr_o, 32'h0000_1A33);
    chk("R6 illegal store", {31'h0, mem_req_o}, 32'h0);
    idle();

    // store sweep: every code at every lane offset
    for (int f = 0; f < 8; f++) begin
      for (int a = 0; a < 4; a++) begin
        logic [31:0] sd;
        bit legal, mis, rq;
        logic [3:0] be;
        sd = 32'hA1B2_C3D4 ^ {f[7:0], a[7:0], 16'h5A0F};
        legal = (f <= 2);
        mis = legal && ((f == 1 && a[0]) || (f == 2 && a != 0));
        rq = legal && !mis;
        be = !rq ? 4'h0 : (f == 0) ? (4'h1 << a) : (f == 1) ? (a[1] ? 4'hC : 4'h3) : 4'hF;
        drive(1'b1, 3'(f), 32'h0000_0020, 12'(a), sd);
        chk("R2 store", {31'h0, misaligned_o}, {31'h0, mis});
        chk(legal ? "R3 store" : "R6 store", {31'h0, mem_req_o}, {31'h0, rq});
        chk("R4 store", {28'h0, mem_be_o}, {28'h0, be});
        for (int l = 0; l < 4; l++)
          if (be[l])
            chk("R5", {24'h0, mem_wdata_o[8*l +: 8]},
                {24'h0, (f == 0) ? sd[7:0] : (f == 1) ? sd[8*(l%2) +: 8] : sd[8*l +: 8]});
        idle();
      end
    end

    // load sweep over two words with lanes on both sides of the sign boundary
    mem[0] = 32'h80FF_7F01;
    mem[1] = 32'h7F01_80FE;
    for (int w = 0; w < 2; w++) begin
      for (int f = 0; f < 8; f++) begin
        for (int a = 0; a < 4; a++) begin
          bit legal, mis, rq;
          legal = (f <= 2) || f == 4 || f == 5;
          mis = legal && (((f == 1 || f == 5) && a[0]) || (f == 2 && a != 0));
          rq = legal && !mis;
          drive(1'b0, 3'(f), 32'(w * 4), 12'(a), 32'hFFFF_FFFF);
          chk("R2 load", {31'h0, misaligned_o}, {31'h0, mis});
          chk(legal ? "R3 load" : "R6 load", {31'h0, mem_req_o}, {31'h0, rq});
          chk("R4 load", {28'h0, mem_be_o}, 32'h0);
          idle();
          chk("R7", {31'h0, load_valid_o}, {31'h0, rq});
          if (rq)
            chk((f == 2) ? "R8" : (f >= 4) ? "R10" : "R9", load_data_o,
                exp_load(f, a, mem[w]));
        end
      end
    end
    @(negedge clk_i); #1;
    chk("R7 idle", {31'h0, load_valid_o}, 32'h0);

    // round trip through memory: lanes and suppression observed by reading back
    drive(1'b1, 3'b000, 32'h0000_0010, 12'h002, 32'h1234_565A); idle();
    drive(1'b1, 3'b001, 32'h0000_0010, 12'h000, 32'h7777_BEEF); idle();
    load_word(32'h0000_0010, 32'h005A_BEEF, "R4 R5 roundtrip");
    drive(1'b1, 3'b000, 32'h0000_0013, 12'h000, 32'hFFFF_FF80); idle();
    load_word(32'h0000_0010, 32'h805A_BEEF, "R5 byte lane 3");
    drive(1'b1, 3'b010, 32'h0000_0011, 12'h000, 32'hFFFF_FFFF);
    chk("R3 misaligned word", {31'h0, misaligned_o}, 32'h1);
    idle();
    load_word(32'h0000_0010, 32'h805A_BEEF, "R3 memory unchanged");
    drive(1'b1, 3'b001, 32'h0000_0012, 12'h000, 32'h0000_1357); idle();
    load_word(32'h0000_0010, 32'h1357_BEEF, "R4 upper half");
    drive(1'b0, 3'b000, 32'h0000_0014, 12'hFFF, 32'h0); idle();
    chk("R9 byte via negative offset", load_data_o, 32'h0000_0013);
    drive(1'b0, 3'b001, 32'h0000_0010, 12'h000, 32'h0); idle();
    chk("R9 half negative", load_data_o, 32'hFFFF_BEEF);

    @(negedge clk_i);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule